// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits behind the host write port of a parallel NOR flash controller. It sees each latched host write cycle as one clock-wide strobe carrying a word address and a word of data. It tracks the multi-cycle unlock handshakes that guard every data-altering command. When a sequence completes, it issues a single decoded operation strobe carrying an operation code, a target address and the written data. Storage, timers and analog control lie downstream and are not part of this block.

The block also owns the current read mode. In array mode reads are left to the storage. In the identification, query and security modes the block supplies the read word itself. It keeps the sixteen-word security space: eight factory words derived from a seed, and eight user words that can be programmed once and then locked. It refuses program and erase requests aimed at one boot block while the protect pin is low. A busy input from the internal engine makes it ignore commands while an operation runs. The only exception is the erase suspend request.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `mode_o` is 0 (array), `rd_hit_o` is 0, no operation strobe is issued, all user security words read FFFF and the user space is unlocked. A cycle without `wr_valid_i` never produces `op_valid_o` in the next cycle.
- R2: The writes AA@5555, 55@2AAA and A0@5555, followed by a fourth write, produce one `op_valid_o` pulse in the cycle after the fourth write. That pulse carries `op_kind_o`=1 (program) and the fourth write's address and data. Operation codes: 1 program, 2 sector erase, 3 block erase, 4 chip erase, 5 suspend, 6 resume, 7 security program, 8 security lock.
- R3: While matching a sequence, only address bits 14..0 and data bits 7..0 are compared. The other bits do not affect decoding.
- R4: The prefix AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA is followed by a sixth write. Data 30 gives code 2 with the address's low 11 bits cleared. Data 50 gives code 3 with the low 15 bits cleared. Data 10 at 5555 gives code 4 with address 0.
- R5: A third-cycle code of 90, 98 or 88 sets `mode_o` to 1 (ID), 2 (query) or 3 (security), and a third-cycle F0 sets 0. A single write of 98 at address 55 sets mode 2. A single write of F0 at any address sets mode 0.
- R6: Any write that does not fit the expected next step of a sequence sets mode 0 and restarts matching from the first cycle.
- R7: While `busy_i` is high, every write is ignored, including exit. The only exception is B0 during a running erase. Mode and sequence position stay unchanged.
- R8: A single B0 write while an erase is running and not suspended gives code 5. It is accepted with `busy_i` high. A single 30 write while suspended and not busy gives code 6. An erase counts as running from its strobe until `busy_i` falls while it is not suspended.
- R9: With `protect_ni` low, program, sector erase and block erase whose address bits 19..15 are all zero complete without a strobe. This applies to the bottom boot block, the default; with BOOT_TOP set it is bits 19..15 all one. Chip erase is dropped entirely. With `protect_ni` high the same requests are issued.
- R10: In mode 1, with `rd_addr_i` bits 19..8 zero, address bit 0 = 0 reads 00BF and bit 0 = 1 reads DEVICE_ID (default 274B). In mode 2, low byte 10, 11, 12 read 0051, 0052, 0059. `rd_hit_o` is 1 in modes 1 to 3.
- R11: In mode 3, addresses 00..07 read factory word i = SID_SEED + i*1111h (seed C3A5), and 08..0F read the user words. Address FF reads 0008 while unlocked and 0000 once locked.
- R12: AA/55/A5 followed by a write to address 8..F gives code 7, and the user word becomes old AND data. A write to a factory address, an address outside 0..F, or any address once locked completes without a strobe and changes nothing.
- R13: AA/55/85 followed by any write gives code 8, and the user space stays locked from the next cycle until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | One latched host write this cycle |
| wr_addr_i | input | 20 | Word address of the write |
| wr_data_i | input | 16 | Data of the write |
| busy_i | input | 1 | Internal program or erase running |
| protect_ni | input | 1 | Boot block protect pin, active low |
| rd_addr_i | input | 20 | Read word address |
| rd_hit_o | output | 1 | Block supplies the read word |
| rd_data_o | output | 16 | Read word in ID, query and security modes |
| mode_o | output | 2 | Read mode: 0 array, 1 ID, 2 query, 3 security |
| op_valid_o | output | 1 | Decoded operation strobe |
| op_kind_o | output | 4 | Operation code |
| op_addr_o | output | 20 | Operation address |
| op_data_o | output | 16 | Operation data |

## Verification
The hardest state to reach is a suspended erase followed by resume. It needs an erase strobe, then `busy_i` raised by the bench as the engine would, a B0 issued while busy, and `busy_i` dropped while suspended so the erase still counts as running. The bench walks that order and then lets busy rise and fall once more. A final B0 then checks that the erase no longer counts as running. A second hard case is the security space after lock, where only reads through the normal port can show that later programs were dropped. Every issued strobe goes through an expected-operation queue, so any strobe that should have been suppressed shows up as unexpected.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int KEY_W = 15;
  localparam logic [KEY_W-1:0] KEY_A = 15'h5555;
  localparam logic [KEY_W-1:0] KEY_B = 15'h2AAA;
  localparam logic [KEY_W-1:0] KEY_Q = 15'h0055;

  localparam logic [7:0] CMD_UNL1   = 8'hAA;
  localparam logic [7:0] CMD_UNL2   = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_BLK    = 8'h50;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;
  localparam logic [7:0] CMD_EXIT   = 8'hF0;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_QUERY  = 8'h98;
  localparam logic [7:0] CMD_SECID  = 8'h88;
  localparam logic [7:0] CMD_SPROG  = 8'hA5;
  localparam logic [7:0] CMD_SLOCK  = 8'h85;

  typedef enum logic [3:0] {
    OP_NONE       = 4'd0,
    OP_PROG       = 4'd1,
    OP_SECT_ERASE = 4'd2,
    OP_BLK_ERASE  = 4'd3,
    OP_CHIP_ERASE = 4'd4,
    OP_SUSPEND    = 4'd5,
    OP_RESUME     = 4'd6,
    OP_SID_PROG   = 4'd7,
    OP_SID_LOCK   = 4'd8
  } op_kind_e;

  typedef enum logic [1:0] {
    RD_ARRAY = 2'd0,
    RD_IDENT = 2'd1,
    RD_QUERY = 2'd2,
    RD_SECID = 2'd3
  } rd_mode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_SPROG, S_LOCK, S_ERA1, S_ERA2, S_ERA3
  } seq_state_e;
endpackage

// File: rtl/fcd_protect.sv
module fcd_protect #(
  parameter int ADDR_W   = 20,
  parameter int BLK_LSB  = 15,
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              protect_ni,
  output logic              blocked_o,
  output logic              chip_lock_o
);
  localparam int TAG_W = ADDR_W - BLK_LSB;

  logic [TAG_W-1:0] tag;
  logic             in_boot;

  assign tag = addr_i[ADDR_W-1:BLK_LSB];

  generate
    if (BOOT_TOP) begin : g_top
      assign in_boot = &tag;
    end else begin : g_bottom
      assign in_boot = ~|tag;
    end
  endgenerate

  assign blocked_o   = ~protect_ni & in_boot;
  assign chip_lock_o = ~protect_ni;
endmodule

// File: rtl/fcd_sid_store.sv
module fcd_sid_store #(
  parameter int              DATA_W = 16,
  parameter int              IDX_W  = 3,
  parameter logic [15:0]     SEED   = 16'hC3A5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              lock_i,
  input  logic [IDX_W:0]    wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W:0]    rd_idx_i,
  output logic [DATA_W-1:0] rd_word_o,
  output logic              locked_o
);
  localparam int          USER_N = 1 << IDX_W;
  localparam logic [15:0] STEP   = 16'h1111;

  logic [USER_N-1:0][DATA_W-1:0] user_q;
  logic                          locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      user_q <= '1;
    end else if (prog_i && wr_idx_i[IDX_W]) begin
      for (int i = 0; i < USER_N; i++) begin
        if (wr_idx_i[IDX_W-1:0] == IDX_W'(i)) user_q[i] <= user_q[i] & wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     locked_q <= 1'b0;
    else if (lock_i) locked_q <= 1'b1;
  end

  // factory half is computed, never stored
  always_comb begin
    if (rd_idx_i[IDX_W]) rd_word_o = user_q[rd_idx_i[IDX_W-1:0]];
    else rd_word_o = DATA_W'(SEED + 16'(rd_idx_i[IDX_W-1:0]) * STEP);
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic              blocked_i,
  input  logic              chip_lock_i,
  input  logic              sid_ok_i,
  output logic              op_valid_o,
  output logic [3:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [1:0]        mode_o
);
  localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_LSB;
  localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_LSB;

  seq_state_e        state_q, state_d;
  rd_mode_e          mode_q, mode_d;
  logic              ers_run_q, ers_d;
  logic              susp_q, susp_d;
  logic              busy_q;
  logic              op_v_d;
  op_kind_e          kind_d, kind_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [DATA_W-1:0] data_d, data_q;
  logic              op_v_q;

  logic       at_a, at_b, at_q;
  logic [7:0] cmd;

  assign at_a = wr_addr_i[KEY_W-1:0] == KEY_A;
  assign at_b = wr_addr_i[KEY_W-1:0] == KEY_B;
  assign at_q = wr_addr_i[KEY_W-1:0] == KEY_Q;
  assign cmd  = wr_data_i[7:0];

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    ers_d   = ers_run_q;
    susp_d  = susp_q;
    op_v_d  = 1'b0;
    kind_d  = OP_NONE;
    addr_d  = wr_addr_i;
    data_d  = wr_data_i;

    // erase finished on its own
    if (busy_q && !busy_i && !susp_q) ers_d = 1'b0;

    if (wr_valid_i) begin
      if (busy_i) begin
        if (cmd == CMD_SUSP && ers_run_q && !susp_q) begin
          op_v_d = 1'b1;
          kind_d = OP_SUSPEND;
          susp_d = 1'b1;
        end
      end else begin
        state_d = S_IDLE;
        unique case (state_q)
          S_IDLE: begin
            if (cmd == CMD_UNL1 && at_a) begin
              state_d = S_UNL1;
            end else if (cmd == CMD_SUSP && ers_run_q && !susp_q) begin
              op_v_d = 1'b1;
              kind_d = OP_SUSPEND;
              susp_d = 1'b1;
            end else if (cmd == CMD_RESUME && susp_q) begin
              op_v_d = 1'b1;
              kind_d = OP_RESUME;
              susp_d = 1'b0;
            end else if (cmd == CMD_QUERY && at_q) begin
              mode_d = RD_QUERY;
            end else begin
              mode_d = RD_ARRAY;  // exit or unrecognised
            end
          end
          S_UNL1: begin
            if (cmd == CMD_UNL2 && at_b) state_d = S_UNL2;
            else mode_d = RD_ARRAY;
          end
          S_UNL2: begin
            if (!at_a) begin
              mode_d = RD_ARRAY;
            end else begin
              unique case (cmd)
                CMD_PROG:  state_d = S_PROG;
                CMD_SPROG: state_d = S_SPROG;
                CMD_SLOCK: state_d = S_LOCK;
                CMD_ERASE: state_d = S_ERA1;
                CMD_IDENT: mode_d = RD_IDENT;
                CMD_QUERY: mode_d = RD_QUERY;
                CMD_SECID: mode_d = RD_SECID;
                default:   mode_d = RD_ARRAY;
              endcase
            end
          end
          S_PROG: begin
            if (!blocked_i) begin
              op_v_d = 1'b1;
              kind_d = OP_PROG;
            end
          end
          S_SPROG: begin
            if (sid_ok_i) begin
              op_v_d = 1'b1;
              kind_d = OP_SID_PROG;
            end
          end
          S_LOCK: begin
            op_v_d = 1'b1;
            kind_d = OP_SID_LOCK;
          end
          S_ERA1: begin
            if (cmd == CMD_UNL1 && at_a) state_d = S_ERA2;
            else mode_d = RD_ARRAY;
          end
          S_ERA2: begin
            if (cmd == CMD_UNL2 && at_b) state_d = S_ERA3;
            else mode_d = RD_ARRAY;
          end
          S_ERA3: begin
            if (susp_q) begin
              mode_d = RD_ARRAY;
            end else if (cmd == CMD_SECT) begin
              if (!blocked_i) begin
                op_v_d = 1'b1;
                kind_d = OP_SECT_ERASE;
                addr_d = wr_addr_i & SECT_MASK;
                ers_d  = 1'b1;
              end
            end else if (cmd == CMD_BLK) begin
              if (!blocked_i) begin
                op_v_d = 1'b1;
                kind_d = OP_BLK_ERASE;
                addr_d = wr_addr_i & BLK_MASK;
                ers_d  = 1'b1;
              end
            end else if (cmd == CMD_CHIP && at_a) begin
              if (!chip_lock_i) begin
                op_v_d = 1'b1;
                kind_d = OP_CHIP_ERASE;
                addr_d = '0;
                ers_d  = 1'b1;
              end
            end else begin
              mode_d = RD_ARRAY;
            end
          end
          default: mode_d = RD_ARRAY;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      mode_q    <= RD_ARRAY;
      ers_run_q <= 1'b0;
      susp_q    <= 1'b0;
      busy_q    <= 1'b0;
      op_v_q    <= 1'b0;
      kind_q    <= OP_NONE;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      state_q   <= state_d;
      mode_q    <= mode_d;
      ers_run_q <= ers_d;
      susp_q    <= susp_d;
      busy_q    <= busy_i;
      op_v_q    <= op_v_d;
      kind_q    <= kind_d;
      addr_q    <= addr_d;
      data_q    <= data_d;
    end
  end

  assign op_valid_o = op_v_q;
  assign op_kind_o  = kind_q;
  assign op_addr_o  = addr_q;
  assign op_data_o  = data_q;
  assign mode_o     = mode_q;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter int          DATA_W    = 16,
  parameter int          SECT_LSB  = 11,
  parameter int          BLK_LSB   = 15,
  parameter bit          BOOT_TOP  = 1'b0,
  parameter logic [15:0] MFR_ID    = 16'h00BF,
  parameter logic [15:0] DEVICE_ID = 16'h274B,
  parameter int          SID_IDX_W = 3,
  parameter logic [15:0] SID_SEED  = 16'hC3A5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic              protect_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_hit_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [1:0]        mode_o,
  output logic              op_valid_o,
  output logic [3:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o
);
  localparam int SID_AW = SID_IDX_W + 1;

  logic              blocked, chip_lock, sid_locked, sid_ok;
  logic [DATA_W-1:0] sid_word;
  logic              rd_hi_zero;
  logic [7:0]        rd_lo;

  fcd_protect #(
    .ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .BOOT_TOP(BOOT_TOP)
  ) i_protect (
    .addr_i     (wr_addr_i),
    .protect_ni (protect_ni),
    .blocked_o  (blocked),
    .chip_lock_o(chip_lock)
  );

  // user half only, inside the security window, not yet locked
  assign sid_ok = (wr_addr_i[ADDR_W-1:SID_AW] == '0) && wr_addr_i[SID_IDX_W] && !sid_locked;

  fcd_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .busy_i     (busy_i),
    .blocked_i  (blocked),
    .chip_lock_i(chip_lock),
    .sid_ok_i   (sid_ok),
    .op_valid_o (op_valid_o),
    .op_kind_o  (op_kind_o),
    .op_addr_o  (op_addr_o),
    .op_data_o  (op_data_o),
    .mode_o     (mode_o)
  );

  fcd_sid_store #(
    .DATA_W(DATA_W), .IDX_W(SID_IDX_W), .SEED(SID_SEED)
  ) i_sid (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .prog_i   (op_valid_o && op_kind_o == OP_SID_PROG),
    .lock_i   (op_valid_o && op_kind_o == OP_SID_LOCK),
    .wr_idx_i (op_addr_o[SID_AW-1:0]),
    .wr_data_i(op_data_o),
    .rd_idx_i (rd_addr_i[SID_AW-1:0]),
    .rd_word_o(sid_word),
    .locked_o (sid_locked)
  );

  assign rd_hi_zero = rd_addr_i[ADDR_W-1:8] == '0;
  assign rd_lo      = rd_addr_i[7:0];
  assign rd_hit_o   = mode_o != RD_ARRAY;

  always_comb begin
    rd_data_o = '0;
    if (rd_hi_zero) begin
      unique case (rd_mode_e'(mode_o))
        RD_IDENT: rd_data_o = rd_lo[0] ? DATA_W'(DEVICE_ID) : DATA_W'(MFR_ID);
        RD_QUERY: begin
          unique case (rd_lo)
            8'h10:   rd_data_o = DATA_W'(16'h0051);
            8'h11:   rd_data_o = DATA_W'(16'h0052);
            8'h12:   rd_data_o = DATA_W'(16'h0059);
            default: rd_data_o = '0;
          endcase
        end
        RD_SECID: begin
          if (rd_lo == 8'hFF) rd_data_o = DATA_W'({!sid_locked, 3'b000});
          else if (rd_lo[7:SID_AW] == '0) rd_data_o = sid_word;
        end
        default: rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/fcd_chk.sv
module fcd_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_valid_i,
  input logic [15:0] wr_data_i,
  input logic       busy_i,
  input logic       protect_ni,
  input logic [1:0] mode_o,
  input logic       op_valid_o,
  input logic [3:0] op_kind_o,
  input logic       sid_locked
);
  // R2
  op_kind_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> (op_kind_o != 4'd0 && op_kind_o <= 4'd8));

  // R1
  no_write_no_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> !op_valid_o);

  // R7
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && busy_i && wr_data_i[7:0] != 8'hB0) |=> !op_valid_o);

  // R7
  busy_mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && busy_i) |=> $stable(mode_o));

  // R9
  chip_protect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_kind_o == 4'd4) |-> $past(protect_ni));

  // R13
  lock_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_kind_o == 4'd8) |=> sid_locked);

  // R13
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sid_locked |=> sid_locked);
endmodule

bind flash_cmd_decoder fcd_chk i_fcd_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_valid_i(wr_valid_i),
  .wr_data_i (wr_data_i),
  .busy_i    (busy_i),
  .protect_ni(protect_ni),
  .mode_o    (mode_o),
  .op_valid_o(op_valid_o),
  .op_kind_o (op_kind_o),
  .sid_locked(sid_locked)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic        protect_n = 1'b1;
  logic [19:0] rd_addr = '0;
  logic        rd_hit;
  logic [15:0] rd_data;
  logic [1:0]  mode;
  logic        op_valid;
  logic [3:0]  op_kind;
  logic [19:0] op_addr;
  logic [15:0] op_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [39:0] exp_q[$];

  always #10 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_i(busy), .protect_ni(protect_n), .rd_addr_i(rd_addr),
    .rd_hit_o(rd_hit), .rd_data_o(rd_data), .mode_o(mode), .op_valid_o(op_valid),
    .op_kind_o(op_kind), .op_addr_o(op_addr), .op_data_o(op_data)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every strobe must match the head of the expectation queue
  always @(negedge clk) begin
    if (rst_n && op_valid) begin
      if (exp_q.size() == 0) check("R2 unexpected strobe", {op_kind, op_addr, op_data}, 40'h0);
      else check("R2 strobe", {op_kind, op_addr, op_data}, exp_q.pop_front());
    end
  end

  task automatic expect_op(input logic [3:0] k, input logic [19:0] a, input logic [15:0] d);
    exp_q.push_back({k, a, d});
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic cmd3(input logic [7:0] c);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, {8'h00, c});
  endtask

  task automatic era5();
    cmd3(8'h80);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
  endtask

  task automatic rd(input logic [19:0] a, input logic [15:0] exp, input string req);
    rd_addr = a;
    #1;
    check(req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1 mode", {38'h0, mode}, 40'h0);
    check("R1 hit", {39'h0, rd_hit}, 40'h0);
    check("R1 strobe", {39'h0, op_valid}, 40'h0);

    // R2 program
    cmd3(8'hA0);
    expect_op(4'd1, 20'h3C0DE, 16'hBEEF);
    wr(20'h3C0DE, 16'hBEEF);
    // R3 high address and data bits ignored during matching
    wr(20'hA5555, 16'h77AA);
    wr(20'h32AAA, 16'h1255);
    wr(20'hF5555, 16'hFFA0);
    expect_op(4'd1, 20'h00123, 16'h4321);
    wr(20'h00123, 16'h4321);

    // R4 erase variants
    era5();
    expect_op(4'd2, 20'h43800, 16'hFF30);
    wr(20'h43A7F, 16'hFF30);
    era5();
    expect_op(4'd3, 20'h40000, 16'h0050);
    wr(20'h43A7F, 16'h0050);
    era5();
    expect_op(4'd4, 20'h00000, 16'h0010);
    wr(20'h05555, 16'h0010);
    busy = 1'b1; idle(2); busy = 1'b0; idle(2);

    // R5 R10 ID mode and single exit
    cmd3(8'h90);
    check("R5 ID entry", {38'h0, mode}, 40'd1);
    check("R10 hit", {39'h0, rd_hit}, 40'd1);
    rd(20'h00000, 16'h00BF, "R10 mfr");
    rd(20'h00001, 16'h274B, "R10 device");
    wr(20'h12345, 16'h00F0);
    check("R5 single exit", {38'h0, mode}, 40'd0);

    // R5 R10 query shortcut, full-sequence exit
    wr(20'h00055, 16'h0098);
    check("R5 query shortcut", {38'h0, mode}, 40'd2);
    rd(20'h00010, 16'h0051, "R10 Q");
    rd(20'h00012, 16'h0059, "R10 Y");
    cmd3(8'hF0);
    check("R5 sequence exit", {38'h0, mode}, 40'd0);

    // R6 abort then restart
    cmd3(8'h90);
    wr(20'h05555, 16'h00AA);
    wr(20'h01234, 16'h0055);
    check("R6 abort", {38'h0, mode}, 40'd0);
    cmd3(8'h98);
    check("R6 restart", {38'h0, mode}, 40'd2);

    // R7 busy: commands and exit ignored
    cmd3(8'h90);
    busy = 1'b1;
    cmd3(8'hA0);
    wr(20'h00100, 16'h1234);
    wr(20'h00000, 16'h00F0);
    check("R7 exit ignored", {38'h0, mode}, 40'd1);
    busy = 1'b0;
    wr(20'h00000, 16'h00F0);
    check("R7 exit after busy", {38'h0, mode}, 40'd0);

    // R8 suspend/resume
    era5();
    expect_op(4'd4, 20'h00000, 16'h0010);
    wr(20'h05555, 16'h0010);
    busy = 1'b1;
    expect_op(4'd5, 20'h12345, 16'h00B0);
    wr(20'h12345, 16'h00B0);
    busy = 1'b0; idle(2);
    expect_op(4'd6, 20'h00777, 16'h0030);
    wr(20'h00777, 16'h0030);
    busy = 1'b1; idle(2); busy = 1'b0; idle(2);
    wr(20'h00000, 16'h00B0);
    check("R8 no suspend after finish", {38'h0, mode}, 40'd0);

    // R9 protection of bottom boot block
    protect_n = 1'b0;
    cmd3(8'hA0);
    wr(20'h00100, 16'h5555);
    cmd3(8'hA0);
    expect_op(4'd1, 20'h08000, 16'h6666);
    wr(20'h08000, 16'h6666);
    era5();
    wr(20'h07800, 16'h0030);
    era5();
    wr(20'h05555, 16'h0010);
    protect_n = 1'b1;
    cmd3(8'hA0);
    expect_op(4'd1, 20'h00100, 16'h7777);
    wr(20'h00100, 16'h7777);

    // R11 R12 R13 security space
    cmd3(8'h88);
    check("R5 security entry", {38'h0, mode}, 40'd3);
    rd(20'h00000, 16'hC3A5, "R11 factory 0");
    rd(20'h00003, 16'hF6D8, "R11 factory 3");
    rd(20'h00009, 16'hFFFF, "R11 user blank");
    rd(20'h000FF, 16'h0008, "R11 unlocked");
    cmd3(8'hA5);
    expect_op(4'd7, 20'h00009, 16'hF0F3);
    wr(20'h00009, 16'hF0F3);
    idle(1);
    rd(20'h00009, 16'hF0F3, "R12 program");
    cmd3(8'hA5);
    expect_op(4'd7, 20'h00009, 16'h0FFF);
    wr(20'h00009, 16'h0FFF);
    idle(1);
    rd(20'h00009, 16'h00F3, "R12 and-only");
    cmd3(8'hA5);
    wr(20'h00003, 16'h0000);
    idle(1);
    rd(20'h00003, 16'hF6D8, "R12 factory locked");
    cmd3(8'hA5);
    wr(20'h00019, 16'h0000);
    cmd3(8'h85);
    expect_op(4'd8, 20'h00000, 16'h0000);
    wr(20'h00000, 16'h0000);
    idle(1);
    rd(20'h000FF, 16'h0000, "R13 locked status");
    cmd3(8'hA5);
    wr(20'h00009, 16'h0000);
    idle(1);
    rd(20'h00009, 16'h00F3, "R12 locked drop");

    idle(4);
    check("R2 all expected strobes seen", 40'(exp_q.size()), 40'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule